// File: doc/BRIEF.md
# NAND Page Column Pointer Decoder

This block sits on the device side of a NAND-style command/address bus and keeps track of which column of a 528-byte page register the next data transfer uses. A single column-address byte cannot reach every column of such a page, so the upper part of the column comes from a pointer that the host selects with a command. The pointer selects one of three regions: the lower main half, the upper main half, or the 16-byte spare tail.

When the first address byte after a command arrives, the block adds it to the base of the selected region to form the starting column. Each read-advance strobe then steps the column by one. At the last column of the page the column either returns to zero and pulses a next-page flag (sequential row reading) or holds, depending on a parameter. In word-wide mode the page is 264 words and only two regions exist. The cell array and the read timing lie outside this block.

Top module: `nand_colptr_top`

## Requirements
- R1: While reset is asserted and directly after it, `col_idx` is 0, `area_code` is 0 (lower main half) and `page_next` is 0.
- R2: A command write (`wr_en`=1, `cle`=1, `ale`=0) of 00h sets `area_code` to 0, and 50h sets it to 2 (spare). Both settings stay in force until another pointer command arrives.
- R3: In byte mode (`x16_mode`=0), command 01h sets `area_code` to 1 (upper main half). In word mode, 01h leaves `area_code` unchanged.
- R4: In byte mode, the first address write (`wr_en`=1, `ale`=1, `cle`=0) after any command loads `col_idx` with base plus offset. The base is 0, 256 or 512 for codes 0, 1 and 2. The offset is the full bus byte for codes 0 and 1, and only bus bits [3:0] for code 2.
- R5: Code 1 applies to one column load only. The cycle after that load, `area_code` reads 0. Codes 0 and 2 are not changed by a column load.
- R6: Address writes after the first one following a command leave `col_idx` unchanged.
- R7: A cycle with `rd_adv`=1 and no bus write raises `col_idx` by one when it is below the last column.
- R8: With `WRAP_AT_END`=1, `rd_adv` at the last column (527 in byte mode, 263 in word mode) sets `col_idx` to 0 and raises `page_next` for exactly one cycle. With `WRAP_AT_END`=0, the column holds at the last column and no pulse is raised.
- R9: Command FFh sets `area_code` to 0 and `col_idx` to 0 in the next cycle, even when the pointer was 1 or 2.
- R10: In word mode, code 2 has base 256 and uses only bus bits [2:0] as the offset.
- R11: A command with any other code leaves `area_code` and `col_idx` unchanged. It still re-arms the column load of R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| x16_mode | input | 1 | 1 selects word-wide page organisation |
| wr_en | input | 1 | Bus write strobe, one cycle per transfer |
| cle | input | 1 | Marks the bus write as a command |
| ale | input | 1 | Marks the bus write as an address byte |
| rd_adv | input | 1 | Advances the column by one |
| bus_in | input | 8 | Command or address byte |
| col_idx | output | COL_W (10) | Current column index |
| area_code | output | 2 | Pointer region: 0 lower half, 1 upper half, 2 spare |
| page_next | output | 1 | One-cycle pulse when the column wraps past the page end |

## Verification
On every cycle, the assertions check the following: the region code stays legal; the column stays inside the page; the one-shot upper-half pointer falls back after a load; a reset command clears both pointer and column; and a read step either adds one or wraps with a pulse. Only the bench scenarios can show the following: that the loaded column is the correct sum of base and masked offset; that later address bytes and unknown commands leave the state alone; that 00h and 50h persist across loads; and how word mode changes the region set and the last column.

// File: rtl/nand_colptr_pkg.sv
package nand_colptr_pkg;

  typedef enum logic [1:0] {
    AREA_LO    = 2'd0,
    AREA_HI    = 2'd1,
    AREA_SPARE = 2'd2
  } area_e;

  localparam logic [7:0] OPC_PTR_LO    = 8'h00;
  localparam logic [7:0] OPC_PTR_HI    = 8'h01;
  localparam logic [7:0] OPC_PTR_SPARE = 8'h50;
  localparam logic [7:0] OPC_RESET     = 8'hFF;

  // Base column of a region for a given organisation.
  function automatic int unsigned region_base(area_e a, logic wide, int unsigned half);
    case (a)
      AREA_HI:    return half;
      AREA_SPARE: return wide ? half : 2 * half;
      default:    return 0;
    endcase
  endfunction

  // Offset taken from the address byte; the spare region masks to its size.
  function automatic int unsigned region_offset(area_e a, logic wide, logic [7:0] b,
                                                int unsigned spare);
    int unsigned span;
    span = wide ? spare / 2 : spare;
    if (a == AREA_SPARE) return int'(b) % span;
    return int'(b);
  endfunction

  function automatic int unsigned page_last(logic wide, int unsigned half, int unsigned spare);
    return wide ? (half + spare / 2 - 1) : (2 * half + spare - 1);
  endfunction

endpackage

// File: rtl/nand_colptr_cmd_dec.sv
module nand_colptr_cmd_dec
  import nand_colptr_pkg::*;
(
  input  logic       wr_en,
  input  logic       cle,
  input  logic       ale,
  input  logic       x16_mode,
  input  logic [7:0] bus_in,
  output logic       cmd_wr,
  output logic       addr_wr,
  output logic       ptr_sel,
  output area_e      ptr_area,
  output logic       soft_rst
);
  assign cmd_wr  = wr_en & cle & ~ale;
  assign addr_wr = wr_en & ale & ~cle;

  always_comb begin
    ptr_sel  = 1'b0;
    ptr_area = AREA_LO;
    soft_rst = 1'b0;
    if (cmd_wr) begin
      case (bus_in)
        OPC_PTR_LO:    ptr_sel = 1'b1;
        OPC_PTR_HI:    begin ptr_sel = ~x16_mode; ptr_area = AREA_HI; end
        OPC_PTR_SPARE: begin ptr_sel = 1'b1; ptr_area = AREA_SPARE; end
        OPC_RESET:     soft_rst = 1'b1;
        default:       ptr_sel = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/nand_colptr_area_reg.sv
module nand_colptr_area_reg
  import nand_colptr_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  ptr_sel,
  input  area_e ptr_area,
  input  logic  soft_rst,
  input  logic  col_load,
  output area_e area_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)                           area_q <= AREA_LO;
    else if (soft_rst)                    area_q <= AREA_LO;
    else if (ptr_sel)                     area_q <= ptr_area;
    else if (col_load && area_q == AREA_HI) area_q <= AREA_LO;
  end

  p_area_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    area_q != 2'd3);

  p_hi_oneshot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (col_load && !ptr_sel && !soft_rst && area_q == AREA_HI) |=> area_q == AREA_LO);

  p_keep_on_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (col_load && !ptr_sel && !soft_rst && area_q != AREA_HI) |=> $stable(area_q));
endmodule

// File: rtl/nand_colptr_col_ctr.sv
module nand_colptr_col_ctr #(
  parameter int COL_W       = 10,
  parameter bit WRAP_AT_END = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             load,
  input  logic [COL_W-1:0] load_val,
  input  logic             adv,
  input  logic [COL_W-1:0] last_col,
  output logic [COL_W-1:0] col_q,
  output logic             page_next
);
  logic [COL_W-1:0] end_val;
  logic             end_pulse;
  logic             at_end;

  assign at_end = (col_q >= last_col);

  generate
    if (WRAP_AT_END) begin : g_wrap
      assign end_val   = '0;
      assign end_pulse = 1'b1;
    end else begin : g_hold
      assign end_val   = last_col;
      assign end_pulse = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      col_q     <= '0;
      page_next <= 1'b0;
    end else begin
      page_next <= 1'b0;
      if (clear)     col_q <= '0;
      else if (load) col_q <= load_val;
      else if (adv) begin
        if (at_end) begin
          col_q     <= end_val;
          page_next <= end_pulse;
        end else begin
          col_q <= col_q + 1'b1;
        end
      end
    end
  end

  p_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !clear && !load && !at_end) |=> col_q == $past(col_q) + 1'b1);

  p_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !clear && !load && at_end) |=> (col_q == end_val && page_next == end_pulse));

  p_pulse_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(page_next) |-> $past(adv));
endmodule

// File: rtl/nand_colptr_top.sv
module nand_colptr_top
  import nand_colptr_pkg::*;
#(
  parameter int HALF_COLS   = 256,
  parameter int SPARE_COLS  = 16,
  parameter bit WRAP_AT_END = 1'b1,
  parameter int COL_W       = $clog2(2 * HALF_COLS + SPARE_COLS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             x16_mode,
  input  logic             wr_en,
  input  logic             cle,
  input  logic             ale,
  input  logic             rd_adv,
  input  logic [7:0]       bus_in,
  output logic [COL_W-1:0] col_idx,
  output logic [1:0]       area_code,
  output logic             page_next
);
  logic             cmd_wr, addr_wr, ptr_sel, soft_rst;
  area_e            ptr_area, area_q;
  logic             first_addr_q;
  logic             col_load;
  logic [COL_W-1:0] load_val, last_col;

  nand_colptr_cmd_dec u_dec (
    .wr_en(wr_en), .cle(cle), .ale(ale), .x16_mode(x16_mode), .bus_in(bus_in),
    .cmd_wr(cmd_wr), .addr_wr(addr_wr), .ptr_sel(ptr_sel), .ptr_area(ptr_area),
    .soft_rst(soft_rst)
  );

  // Column load armed by any command, consumed by the next address byte.
  always_ff @(posedge clk) begin
    if (!rst_n)       first_addr_q <= 1'b1;
    else if (cmd_wr)  first_addr_q <= 1'b1;
    else if (addr_wr) first_addr_q <= 1'b0;
  end

  assign col_load = addr_wr & first_addr_q;
  assign load_val = COL_W'(region_base(area_q, x16_mode, HALF_COLS)
                         + region_offset(area_q, x16_mode, bus_in, SPARE_COLS));
  assign last_col = COL_W'(page_last(x16_mode, HALF_COLS, SPARE_COLS));

  nand_colptr_area_reg u_area (
    .clk(clk), .rst_n(rst_n), .ptr_sel(ptr_sel), .ptr_area(ptr_area),
    .soft_rst(soft_rst), .col_load(col_load), .area_q(area_q)
  );

  nand_colptr_col_ctr #(.COL_W(COL_W), .WRAP_AT_END(WRAP_AT_END)) u_ctr (
    .clk(clk), .rst_n(rst_n), .clear(soft_rst), .load(col_load), .load_val(load_val),
    .adv(rd_adv & ~wr_en), .last_col(last_col), .col_q(col_idx), .page_next(page_next)
  );

  assign area_code = area_q;

  p_soft_reset_r9: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (col_idx == '0 && area_code == 2'd0));

  p_col_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    col_idx <= last_col || $past(x16_mode) != x16_mode);

  p_late_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_wr && !first_addr_q) |=> $stable(col_idx));
endmodule

// File: tb/nand_colptr_top_tb_top.sv
module nand_colptr_top_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       x16_mode = 1'b0, wr_en = 1'b0, cle = 1'b0, ale = 1'b0, rd_adv = 1'b0;
  logic [7:0] bus_in = 8'h00;
  logic [9:0] col_idx;
  logic [1:0] area_code;
  logic       page_next;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  nand_colptr_top dut_i (
    .clk(clk), .rst_n(rst_n), .x16_mode(x16_mode), .wr_en(wr_en), .cle(cle), .ale(ale),
    .rd_adv(rd_adv), .bus_in(bus_in), .col_idx(col_idx), .area_code(area_code),
    .page_next(page_next)
  );

  // op: 0 command, 1 address, 2 read step, 3 idle
  // entry = {op[1:0], data[7:0], col[9:0], area[1:0], pulse}
  localparam int NV = 17;
  localparam logic [22:0] VEC [NV] = '{
    {2'd0, 8'h00, 10'd0,   2'd0, 1'b0},  // R2 pointer low
    {2'd1, 8'h05, 10'd5,   2'd0, 1'b0},  // R4 load low half
    {2'd2, 8'h00, 10'd6,   2'd0, 1'b0},  // R7 step
    {2'd1, 8'h33, 10'd6,   2'd0, 1'b0},  // R6 late address ignored
    {2'd0, 8'h01, 10'd6,   2'd1, 1'b0},  // R3 upper pointer
    {2'd1, 8'h10, 10'd272, 2'd0, 1'b0},  // R4/R5 upper load, one-shot
    {2'd0, 8'h50, 10'd272, 2'd2, 1'b0},  // R2 spare pointer
    {2'd1, 8'hF3, 10'd515, 2'd2, 1'b0},  // R4 spare masks high bits
    {2'd2, 8'h00, 10'd516, 2'd2, 1'b0},  // R7 step in spare
    {2'd0, 8'h80, 10'd516, 2'd2, 1'b0},  // R11 unknown command
    {2'd1, 8'h0F, 10'd527, 2'd2, 1'b0},  // R5 spare persists
    {2'd2, 8'h00, 10'd0,   2'd2, 1'b1},  // R8 wrap with pulse
    {2'd3, 8'h00, 10'd0,   2'd2, 1'b0},  // R8 pulse one cycle
    {2'd2, 8'h00, 10'd1,   2'd2, 1'b0},  // R7 step after wrap
    {2'd0, 8'hFF, 10'd0,   2'd0, 1'b0},  // R9 reset from spare
    {2'd0, 8'h01, 10'd0,   2'd1, 1'b0},  // R3
    {2'd0, 8'hFF, 10'd0,   2'd0, 1'b0}   // R9 reset from upper
  };

  task automatic check(string req, logic [9:0] ec, logic [1:0] ea, logic ep);
    checks++;
    if (col_idx !== ec || area_code !== ea || page_next !== ep) begin
      errors++;
      $display("FAIL %s: col=%0d area=%0d pulse=%0d expected col=%0d area=%0d pulse=%0d",
               req, col_idx, area_code, page_next, ec, ea, ep);
    end
  endtask

  task automatic do_op(logic [1:0] op, logic [7:0] d);
    @(negedge clk);
    wr_en  = (op == 2'd0 || op == 2'd1);
    cle    = (op == 2'd0);
    ale    = (op == 2'd1);
    rd_adv = (op == 2'd2);
    bus_in = d;
    @(posedge clk);
    #2;
    wr_en = 1'b0; cle = 1'b0; ale = 1'b0; rd_adv = 1'b0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 check("R1 in reset", 10'd0, 2'd0, 1'b0);
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk);
    #2 check("R1 after reset", 10'd0, 2'd0, 1'b0);

    for (int i = 0; i < NV; i++) begin
      do_op(VEC[i][22:21], VEC[i][20:13]);
      check($sformatf("vector %0d", i), VEC[i][12:3], VEC[i][2:1], VEC[i][0]);
    end

    // R6: second address after upper pointer must not reload or revert again
    do_op(2'd0, 8'h01);
    do_op(2'd1, 8'h02);
    check("R5 upper one-shot", 10'd258, 2'd0, 1'b0);
    do_op(2'd1, 8'h44);
    check("R6 row byte ignored", 10'd258, 2'd0, 1'b0);

    // Word mode
    x16_mode = 1'b1;
    do_op(2'd0, 8'h00);
    do_op(2'd0, 8'h01);
    check("R3 upper ignored in word mode", 10'd258, 2'd0, 1'b0);
    do_op(2'd0, 8'h50);
    do_op(2'd1, 8'hFF);
    check("R10 word spare load", 10'd263, 2'd2, 1'b0);
    do_op(2'd2, 8'h00);
    check("R8 word wrap", 10'd0, 2'd2, 1'b1);
    do_op(2'd0, 8'h50);
    do_op(2'd1, 8'h02);
    do_op(2'd2, 8'h00);
    check("R10 word spare step", 10'd259, 2'd2, 1'b0);
    x16_mode = 1'b0;

    // R1: reset mid-run
    do_op(2'd0, 8'h00);
    do_op(2'd1, 8'h07);
    @(negedge clk) rst_n = 1'b0;
    @(posedge clk);
    #2 check("R1 mid-run reset", 10'd0, 2'd0, 1'b0);
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk);
    #2 check("R1 released", 10'd0, 2'd0, 1'b0);

    finish_run();
  end
endmodule